// File: doc/BRIEF.md
# GFSK Symbol-Clock and Frequency-Ramp Generator

This block is the digital front end of a fractional-N transmitter that uses two-level frequency shift keying, either with hard steps or with a smoothed, staircase transition. It divides the phase-detector reference clock (`clk`) into a symbol clock, `sym_clk_o`, which goes out to the host. The host changes its data bit after each falling edge of that clock. The block captures the bit once per symbol, at the clock edge where `sym_clk_o` rises, which is the middle of the bit as the host sees it.

From the captured bits the block produces a signed frequency-offset word, `freq_ofs_o`. This word is added to the synthesizer's fractional word. Its unit is one step of the reference frequency divided by 2^14.

- In hard-step mode the offset jumps between −dev and +dev.
- In smoothed mode it moves between the two levels in 16, 32, 64 or 128 equal steps. One step is taken per prescaler tick, so one full transition fills exactly one symbol period.

All configuration inputs are captured at a symbol boundary. Changing them at any other time does not disturb the symbol in progress.

Top module: `gfsk_ramp_gen`

## Requirements
- R1: While `rst_n` is low, `sym_clk_o` is 0 and `freq_ofs_o` equals −dev for the configuration presented on the inputs.
- R2: With D = `div_i`, where a value of 0 acts as 1, and N steps, a prescaler tick occurs every D cycles. The first rise of `sym_clk_o` comes 1 + D·N/2 cycles after reset is released. After that, `sym_clk_o` has a period of D·N cycles and is high for D·N/2 of them.
- R3: `idx_i` selects the number of steps per symbol: 0 gives N=16, 1 gives N=32, 2 gives N=64 and 3 gives N=128.
- R4: `tx_bit_i` is captured only at the clock edge where `sym_clk_o` rises, exactly once per symbol. Changes to `tx_bit_i` at any other time have no effect.
- R5: When `mode_i` = 2'b00 (hard-step mode), dev = `fsk_dev_i`. From the capturing edge onward, `freq_ofs_o` is +dev for a captured 1 and −dev for a captured 0.
- R6: When `mode_i` ≠ 2'b00 (smoothed mode), dev = 2^(`gexp_i`+2). This equals 2^`gexp_i` units of the reference frequency divided by 2^12.
- R7: In smoothed mode, a captured bit that differs from the previous target starts a transition. The step index k is 1 at the capturing edge and rises by 1 on each later tick, stopping at N. The offset is −dev + ⌊2·dev·k/N⌋ when rising and +dev − ⌊2·dev·k/N⌋ when falling.
- R8: In smoothed mode, a captured bit equal to the previous target holds `freq_ofs_o` at that level for the whole symbol.
- R9: `mode_i`, `div_i`, `idx_i`, `fsk_dev_i` and `gexp_i` take effect only at a rising edge of `sym_clk_o`, or in the first cycle after reset. A value present at the rising edge governs the symbol that starts at that edge.
- R10: `freq_ofs_o` changes only at tick edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at the phase-detector rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_bit_i | input | 1 | Data bit from the host |
| mode_i | input | 2 | 2'b00 selects hard-step mode; any other value selects smoothed mode |
| div_i | input | 7 | Prescaler divide factor D |
| idx_i | input | 2 | Selects the number of steps per symbol |
| fsk_dev_i | input | 9 | Deviation in hard-step mode, in offset units |
| gexp_i | input | 3 | Deviation exponent for smoothed mode |
| sym_clk_o | output | 1 | Symbol clock sent to the host |
| freq_ofs_o | output | 12 | Signed frequency-offset word |

## Verification
Three events share the rising edge of `sym_clk_o`: the data bit is captured, the transition restarts, and the configuration is taken over. The bench changes the configuration in the cycle just before a rise, and in another run in the middle of a symbol. It then checks that the symbol which is ending keeps its old period and offset sequence, while the next symbol's step count, deviation and period follow the new values. The bench also flips `tx_bit_i` inside both halves of each symbol. This shows that only the value present at the rise steers the offset.

// File: rtl/gfsk_ramp_gen.sv
module gfsk_ramp_gen #(
  parameter int DIV_W    = 7,
  parameter int DEV_W    = 9,
  parameter int EXP_W    = 3,
  parameter int IDX_W    = 2,
  parameter int MIN_LOG2 = 4,
  parameter int OFS_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_bit_i,
  input  logic [1:0]              mode_i,
  input  logic [DIV_W-1:0]        div_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DEV_W-1:0]        fsk_dev_i,
  input  logic [EXP_W-1:0]        gexp_i,
  output logic                    sym_clk_o,
  output logic signed [OFS_W-1:0] freq_ofs_o
);
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << IDX_W) - 1;
  localparam int K_W      = MAX_LOG2 + 1;
  localparam int LG_W     = $clog2(MAX_LOG2 + 1);
  localparam int GMAX_W   = (1 << EXP_W) + 2;
  localparam int MAG_W    = (DEV_W > GMAX_W) ? DEV_W : GMAX_W;
  localparam int SH_W     = $clog2(GMAX_W);
  localparam int PROD_W   = MAG_W + K_W + 1;

  logic                    run_q, from_q, to_q;
  logic [1:0]              mode_q;
  logic [DIV_W-1:0]        div_q, pre_q;
  logic [IDX_W-1:0]        idx_q;
  logic [DEV_W-1:0]        fdev_q;
  logic [EXP_W-1:0]        gexp_q;
  logic [K_W-1:0]          ph_q, k_q, nsteps, half, half_in;
  logic [LG_W-1:0]         lg_q, lg_i, lg_e;
  logic                    tick, sample, fsk_e;
  logic [1:0]              mode_e;
  logic [IDX_W-1:0]        idx_e;
  logic [DEV_W-1:0]        fdev_e;
  logic [EXP_W-1:0]        gexp_e;
  logic [MAG_W-1:0]        dev_m;
  logic [PROD_W-1:0]       prod;
  logic signed [OFS_W-1:0] sdev, sdel;

  // timing uses the latched step count; the offset path sees live inputs until running
  assign lg_q    = LG_W'(MIN_LOG2) + LG_W'(idx_q);
  assign lg_i    = LG_W'(MIN_LOG2) + LG_W'(idx_i);
  assign nsteps  = K_W'(1) << lg_q;
  assign half    = nsteps >> 1;
  assign half_in = (K_W'(1) << lg_i) >> 1;

  assign tick      = run_q && (pre_q == ((div_q == '0) ? '0 : div_q - 1'b1));
  assign sample    = tick && (ph_q == half - 1'b1);
  assign sym_clk_o = (ph_q >= half);

  assign mode_e = run_q ? mode_q : mode_i;
  assign idx_e  = run_q ? idx_q  : idx_i;
  assign fdev_e = run_q ? fdev_q : fsk_dev_i;
  assign gexp_e = run_q ? gexp_q : gexp_i;
  assign lg_e   = LG_W'(MIN_LOG2) + LG_W'(idx_e);
  assign fsk_e  = (mode_e == 2'b00);

  assign dev_m = fsk_e ? MAG_W'(fdev_e) : (MAG_W'(1) << (SH_W'(gexp_e) + SH_W'(2)));
  assign prod  = (PROD_W'(dev_m) << 1) * PROD_W'(k_q);
  assign sdel  = OFS_W'(prod >> lg_e);
  assign sdev  = OFS_W'(dev_m);

  assign freq_ofs_o = (fsk_e || (from_q == to_q)) ? (to_q ? sdev : -sdev)
                    : (from_q ? (sdev - sdel) : (sdel - sdev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      from_q <= 1'b0;
      to_q   <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
      idx_q  <= '0;
      fdev_q <= '0;
      gexp_q <= '0;
      pre_q  <= '0;
      ph_q   <= '0;
      k_q    <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      mode_q <= mode_i;
      div_q  <= div_i;
      idx_q  <= idx_i;
      fdev_q <= fsk_dev_i;
      gexp_q <= gexp_i;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick)
        ph_q <= sample ? half_in : ((ph_q == nsteps - 1'b1) ? '0 : ph_q + 1'b1);
      if (sample) begin
        mode_q <= mode_i;
        div_q  <= div_i;
        idx_q  <= idx_i;
        fdev_q <= fsk_dev_i;
        gexp_q <= gexp_i;
        from_q <= to_q;
        to_q   <= tx_bit_i;
        k_q    <= K_W'(1);
      end else if (tick && (k_q < nsteps)) begin
        k_q <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gfsk_ramp_gen_chk.sv
module gfsk_ramp_gen_chk #(
  parameter int K_W   = 8,
  parameter int OFS_W = 12,
  parameter int DEV_W = 9,
  parameter int CFG_W = 23
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_q,
  input logic                    tick,
  input logic                    sample,
  input logic [K_W-1:0]          ph_q,
  input logic [K_W-1:0]          k_q,
  input logic [K_W-1:0]          nsteps,
  input logic                    sym_clk_o,
  input logic signed [OFS_W-1:0] freq_ofs_o,
  input logic [1:0]              mode_q,
  input logic [DEV_W-1:0]        fdev_q,
  input logic [CFG_W-1:0]        cfg_cat
);
  logic signed [OFS_W-1:0] fdev_s;
  assign fdev_s = $signed({{(OFS_W-DEV_W){1'b0}}, fdev_q});

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ph_q < nsteps)); // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (k_q <= nsteps)); // R7
  AST_OFS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(freq_ofs_o)); // R10
  AST_SYMCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(sym_clk_o)); // R2
  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> $rose(sym_clk_o)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sample) |=> $stable(cfg_cat)); // R9
  AST_FSK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (mode_q == 2'b00)) |-> ((freq_ofs_o == fdev_s) || (freq_ofs_o == -fdev_s))); // R5
endmodule

bind gfsk_ramp_gen gfsk_ramp_gen_chk #(
  .K_W(K_W), .OFS_W(OFS_W), .DEV_W(DEV_W), .CFG_W(2 + DIV_W + IDX_W + DEV_W + EXP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .tick(tick), .sample(sample),
  .ph_q(ph_q), .k_q(k_q), .nsteps(nsteps), .sym_clk_o(sym_clk_o),
  .freq_ofs_o(freq_ofs_o), .mode_q(mode_q), .fdev_q(fdev_q),
  .cfg_cat({mode_q, div_q, idx_q, fdev_q, gexp_q})
);

// File: tb/tb_gfsk_ramp_gen.sv
`timescale 1ns/1ps
module tb_gfsk_ramp_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_bit = 1'b0;
  logic [1:0]        mode_i = '0;
  logic [6:0]        div_i = 7'd1;
  logic [1:0]        idx_i = '0;
  logic [8:0]        fsk_dev_i = '0;
  logic [2:0]        gexp_i = '0;
  logic              sym_clk_o;
  logic signed [11:0] freq_ofs_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gfsk_ramp_gen dut (
    .clk(clk), .rst_n(rst_n), .tx_bit_i(tx_bit), .mode_i(mode_i), .div_i(div_i),
    .idx_i(idx_i), .fsk_dev_i(fsk_dev_i), .gexp_i(gexp_i),
    .sym_clk_o(sym_clk_o), .freq_ofs_o(freq_ofs_o)
  );

  function automatic int devf(input int md, input int fm, input int ge);
    return (md == 0) ? fm : (1 << (ge + 2));
  endfunction

  function automatic int deff(input int dv);
    return (dv == 0) ? 1 : dv;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic apply(input int md, input int dv, input int ix, input int fm, input int ge);
    mode_i    = 2'(md);
    div_i     = 7'(dv);
    idx_i     = 2'(ix);
    fsk_dev_i = 9'(fm);
    gexp_i    = 3'(ge);
  endtask

  task automatic run_scn(input int md, input int dv, input int ix, input int fm, input int ge,
                         input int nbits, input logic [15:0] pat, input int chg);
    int c_md, c_dv, c_ix, c_fm, c_ge;
    int cyc, since_rise, since_fall, nrise, from, to, act, expv, k, d, n, per, devv, last;
    int bad_a, bad_e;
    bit sym_ok, stab_ok, prev_sym, s;
    string rtag, xtag;
    xtag = (chg != 0) ? " R9" : "";
    apply(md, dv, ix, fm, ge);
    tx_bit = pat[0];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sym_clk_o == 1'b0, "R1 symbol clock in reset", int'(sym_clk_o), 0);
    chk(int'(freq_ofs_o) == -devf(md, fm, ge), "R1 offset in reset",
        int'(freq_ofs_o), -devf(md, fm, ge));
    if (md != 0)
      chk(int'(freq_ofs_o) == -(1 << (ge + 2)), "R6 smoothed deviation",
          int'(freq_ofs_o), -(1 << (ge + 2)));
    c_md = md; c_dv = dv; c_ix = ix; c_fm = fm; c_ge = ge;
    rst_n = 1'b1;
    cyc = 0; since_rise = 0; since_fall = 0; nrise = 0; from = 0; to = 0;
    prev_sym = 1'b0; sym_ok = 1'b1; stab_ok = 1'b1; bad_a = 0; bad_e = 0;
    last = -devf(md, fm, ge);
    for (int guard = 0; guard < 60000; guard++) begin
      @(negedge clk);
      cyc++;
      s = sym_clk_o;
      d = deff(c_dv); n = 16 << c_ix; per = n * d;
      if (s && !prev_sym) begin
        if (nrise == 0) begin
          chk(cyc == 1 + per / 2, {"R2 R3 first rise", xtag}, cyc, 1 + per / 2);
        end else begin
          chk(since_rise + 1 == per, {"R2 R3 symbol period", xtag}, since_rise + 1, per);
          if (c_md == 0) rtag = "R5 R4 hard-step level";
          else if (from != to) rtag = "R7 R4 transition staircase";
          else rtag = "R8 R4 held level";
          chk(sym_ok, {rtag, xtag}, bad_a, bad_e);
          if (d > 1) chk(stab_ok, "R10 offset moved between ticks", 0, 1);
        end
        if (nrise == nbits) break;
        from = to; to = int'(tx_bit);
        c_md = int'(mode_i); c_dv = int'(div_i); c_ix = int'(idx_i);
        c_fm = int'(fsk_dev_i); c_ge = int'(gexp_i);
        d = deff(c_dv); n = 16 << c_ix; per = n * d;
        since_rise = 0; sym_ok = 1'b1; stab_ok = 1'b1;
        nrise++;
      end else begin
        since_rise++;
      end
      if (!s && prev_sym) begin
        chk(since_rise == per / 2, {"R2 high phase", xtag}, since_rise, per / 2);
        since_fall = 0;
        tx_bit = ~pat[nrise];
      end else begin
        since_fall++;
        if (since_fall == 1 && nrise > 0) tx_bit = pat[nrise];
      end
      if (s && nrise > 0 && since_rise == 1) tx_bit = ~tx_bit;
      devv = devf(c_md, c_fm, c_ge);
      k = 1 + since_rise / d;
      if (k > n) k = n;
      if (c_md == 0 || from == to) expv = (to != 0) ? devv : -devv;
      else if (from != 0) expv = devv - (2 * devv * k) / n;
      else expv = -devv + (2 * devv * k) / n;
      act = int'(freq_ofs_o);
      if (act != expv && sym_ok) begin
        sym_ok = 1'b0; bad_a = act; bad_e = expv;
      end
      if (nrise > 0 && (since_rise % d) != 0 && act != last) stab_ok = 1'b0;
      last = act;
      if (chg == 1 && nrise == 2 && since_rise == 3)
        apply(c_md, c_dv, c_ix ^ 1, c_fm, c_ge ^ 1);
      if (chg == 2 && nrise == 3 && !s && since_fall == per / 2 - 1)
        apply(c_md, c_dv, c_ix ^ 1, c_fm, c_ge ^ 1);
      prev_sym = s;
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R5 hard-step levels, R2 D=0 behaves as D=1
    run_scn(0, 1, 0, 100, 0, 8, 16'b1011_0100_1101_0010, 0);
    run_scn(0, 3, 1, 511, 0, 6, 16'b0000_0000_0011_0110, 0);
    run_scn(0, 0, 0, 37, 0, 6, 16'b0000_0000_0010_1101, 0);
    // R3 R6 R7 R8 sweep of steps, exponent and divider
    for (int ix = 0; ix < 4; ix++)
      for (int ei = 0; ei < 3; ei++)
        for (int dv = 1; dv <= 3; dv += 2)
          run_scn(1, dv, ix, 0, (ei == 0) ? 0 : ((ei == 1) ? 5 : 7), 6,
                  16'b0000_0000_0011_0110, 0);
    // any nonzero mode code selects smoothed mode
    run_scn(3, 2, 0, 0, 4, 6, 16'b0000_0000_0010_1101, 0);
    run_scn(2, 0, 1, 0, 1, 5, 16'b0000_0000_0001_1001, 0);
    // R9 configuration writes mid-symbol and in the cycle before a rise
    run_scn(1, 2, 1, 0, 3, 6, 16'b0000_0000_0010_1101, 1);
    run_scn(1, 1, 0, 0, 2, 6, 16'b0000_0000_0011_0101, 2);
    run_scn(0, 2, 2, 200, 0, 6, 16'b0000_0000_0010_0110, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule